// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This controller fetches 16-bit words from a three-wire serial EEPROM that holds 64 words behind a 6-bit address. It drives the memory's select, clock and data-in lines itself and samples the memory's data-out line. A host requests a word by presenting an address with a one-cycle `start` pulse. The word comes back on `rd_data`, marked by a one-cycle `rd_done`.

Each access has a fixed sequence:
- a setup half-period with select high and clock low;
- an 11-bit command frame made of two leading zeros, a `1` start bit, the read opcode `10` and the six address bits;
- one idle half-period;
- sixteen clock pulses that return the data, most significant bit first;
- a closing half-period with select still high and clock low;
- one half-period with every line low.

The half-period of the serial clock is `div` system clocks. The value is captured when an access starts, and zero is treated as one.

A second request input, `boot_start`, makes the controller read words 7, 8 and 9 back to back. It assembles them into a 48-bit station address and pulses `boot_done` when the address is complete.

Top module: `eeprom_rd_ctrl`

## Requirements
- R1: The command frame is the 11-bit value `(6 << 6) | addr`, shifted out on `ee_di` from bit 10 down to bit 0. The first two bits are therefore zero, followed by `1`, `1`, `0` and the address, most significant bit first.
- R2: Each command bit is placed on `ee_di` while `ee_sk` is low, and `ee_sk` is then raised. `ee_di` never changes while `ee_sk` stays high.
- R3: `ee_cs` stays high from the setup half-period through the closing half-period. `ee_sk` is never high while `ee_cs` is low.
- R4: After the command frame, exactly 16 more clock pulses are issued, giving 27 rising edges per access. `ee_do` is sampled near the end of each high phase, and the bits are assembled most significant bit first.
- R5: An access ends with `ee_cs` high and `ee_sk` low for one half-period, and then all three lines are driven low.
- R6: Every high and low phase of `ee_sk` lasts `div` system clocks, using the value captured at start. A `div` of 0 behaves as 1.
- R7: A `start` or `boot_start` pulse while `busy` is high is ignored. It launches no extra access and does not change the returned word.
- R8: `rd_done` is a one-cycle pulse, and `rd_data` holds the word read when `rd_done` is high. Boot reads raise no `rd_done`.
- R9: `boot_start` reads words 7, 8 and 9 in that order. `mac_addr[47:32]` is word 7, `[31:16]` is word 8 and `[15:0]` is word 9, so each word's high byte is the earlier address byte. `boot_done` pulses once, when all three words are in place.
- R10: After reset `ee_cs`, `ee_sk`, `ee_di`, `busy`, `rd_done`, `boot_done`, `rd_data` and `mac_addr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to read the word at `addr` |
| addr | input | 6 | Word address for a host read |
| div | input | 8 | Serial clock half-period in system clocks (0 acts as 1) |
| boot_start | input | 1 | One-cycle request to load the station address |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM shift clock |
| ee_di | output | 1 | Serial data into the EEPROM |
| ee_do | input | 1 | Serial data out of the EEPROM |
| busy | output | 1 | An access is in progress |
| rd_data | output | 16 | Last word from a host read |
| rd_done | output | 1 | One-cycle pulse: `rd_data` is valid |
| mac_addr | output | 48 | Station address assembled from words 7 to 9 |
| boot_done | output | 1 | One-cycle pulse: `mac_addr` is complete |

## Verification
The embedded properties take for granted that `ee_do` is held steady throughout every high phase of `ee_sk`. They also assume `start` and `boot_start` are synchronous one-cycle pulses. The bench's memory model meets both conditions: it updates `ee_do` only on a rising edge of `ee_sk`, and it drives requests away from the active clock edge. Busy-time requests are deliberately injected in the middle of an access to exercise R7. Only `div` values up to 5 are used, which keeps every access short.

// File: rtl/eeprom_rd_ctrl.sv
module eeprom_rd_ctrl #(
  parameter int DIV_W      = 8,
  parameter int ADDR_W     = 6,
  parameter int WORD_W     = 16,
  parameter int BOOT_BASE  = 7,
  parameter int BOOT_WORDS = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DIV_W-1:0]             div,
  input  logic                         boot_start,
  output logic                         ee_cs,
  output logic                         ee_sk,
  output logic                         ee_di,
  input  logic                         ee_do,
  output logic                         busy,
  output logic [WORD_W-1:0]            rd_data,
  output logic                         rd_done,
  output logic [BOOT_WORDS*WORD_W-1:0] mac_addr,
  output logic                         boot_done
);

  localparam int CMD_W = ADDR_W + 5;
  localparam int MAC_W = BOOT_WORDS * WORD_W;
  localparam int MAXB  = (CMD_W > WORD_W) ? CMD_W : WORD_W;
  localparam int BIT_W = $clog2(MAXB);
  localparam int BI_W  = (BOOT_WORDS > 1) ? $clog2(BOOT_WORDS) : 1;
  localparam logic [2:0] RD_OP = 3'b110;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_CMD, S_GAP, S_DATA, S_HOLD, S_REL} st_t;

  st_t               st;
  logic              ph;
  logic [DIV_W-1:0]  tmr, div_q;
  logic [BIT_W-1:0]  bitc;
  logic [CMD_W-1:0]  cmd_sr;
  logic [WORD_W-1:0] dat_sr;
  logic              booting;
  logic [BI_W-1:0]   bidx;

  wire              tick    = (tmr == '0);
  wire [DIV_W-1:0]  div_eff = (div == '0) ? DIV_W'(1) : div;

  assign busy  = (st != S_IDLE);
  assign ee_cs = (st != S_IDLE) && (st != S_REL);
  assign ee_sk = ((st == S_CMD) && ph) || ((st == S_DATA) && !ph);
  assign ee_di = (st == S_CMD) && cmd_sr[CMD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ph        <= 1'b0;
      tmr       <= '0;
      div_q     <= DIV_W'(1);
      bitc      <= '0;
      cmd_sr    <= '0;
      dat_sr    <= '0;
      booting   <= 1'b0;
      bidx      <= '0;
      rd_data   <= '0;
      rd_done   <= 1'b0;
      mac_addr  <= '0;
      boot_done <= 1'b0;
    end else begin
      rd_done   <= 1'b0;
      boot_done <= 1'b0;
      if (st == S_IDLE) begin
        if (boot_start || start) begin
          booting <= boot_start;
          bidx    <= '0;
          cmd_sr  <= {2'b00, RD_OP, boot_start ? ADDR_W'(BOOT_BASE) : addr};
          div_q   <= div_eff;
          tmr     <= div_eff - DIV_W'(1);
          ph      <= 1'b0;
          st      <= S_SETUP;
        end
      end else begin
        tmr <= tick ? div_q - DIV_W'(1) : tmr - DIV_W'(1);
        if (tick) begin
          case (st)
            S_SETUP: begin
              st   <= S_CMD;
              ph   <= 1'b0;
              bitc <= BIT_W'(CMD_W - 1);
            end
            S_CMD: begin
              if (!ph) ph <= 1'b1;
              else begin
                ph     <= 1'b0;
                cmd_sr <= cmd_sr << 1;
                if (bitc == '0) st <= S_GAP;
                else bitc <= bitc - BIT_W'(1);
              end
            end
            S_GAP: begin
              st   <= S_DATA;
              ph   <= 1'b0;
              bitc <= BIT_W'(WORD_W - 1);
            end
            S_DATA: begin
              if (!ph) begin
                dat_sr <= {dat_sr[WORD_W-2:0], ee_do};
                ph     <= 1'b1;
              end else begin
                ph <= 1'b0;
                if (bitc == '0) st <= S_HOLD;
                else bitc <= bitc - BIT_W'(1);
              end
            end
            S_HOLD: st <= S_REL;
            S_REL: begin
              if (booting) begin
                mac_addr <= {mac_addr[MAC_W-WORD_W-1:0], dat_sr};
                if (bidx == BI_W'(BOOT_WORDS - 1)) begin
                  booting   <= 1'b0;
                  boot_done <= 1'b1;
                  st        <= S_IDLE;
                end else begin
                  bidx   <= bidx + BI_W'(1);
                  cmd_sr <= {2'b00, RD_OP, ADDR_W'(BOOT_BASE + 1) + ADDR_W'(bidx)};
                  ph     <= 1'b0;
                  st     <= S_SETUP;
                end
              end else begin
                rd_data <= dat_sr;
                rd_done <= 1'b1;
                st      <= S_IDLE;
              end
            end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end

  AST_SK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> ee_cs); // R3

  AST_DI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_di)); // R2

  AST_CS_DROP_SK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ee_cs) |-> !$past(ee_sk)); // R5

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done); // R8

  AST_BOOT_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> !boot_done); // R9

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done || boot_done) |-> !busy); // R7

  AST_IDLE_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ee_cs && !ee_sk && !ee_di)); // R10

endmodule

// File: tb/tb_eeprom_rd_ctrl.sv
module tb_eeprom_rd_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [5:0]  addr = 0;
  logic [7:0]  div = 1;
  logic        boot_start = 0;
  logic        ee_cs, ee_sk, ee_di;
  logic        ee_do = 0;
  logic        busy, rd_done, boot_done;
  logic [15:0] rd_data;
  logic [47:0] mac_addr;

  always #5 clk = ~clk;

  eeprom_rd_ctrl dut (
    .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .div(div),
    .boot_start(boot_start), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
    .ee_do(ee_do), .busy(busy), .rd_data(rd_data), .rd_done(rd_done),
    .mac_addr(mac_addr), .boot_done(boot_done));

  int checks = 0;
  int fails  = 0;

  function automatic logic [15:0] memw(input int a);
    logic [31:0] p;
    p = a * 40503 + 777;
    return p[15:0] ^ 16'hA5C3;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int          edges = 0;
  logic [10:0] cmd_seen = 0;
  int          trans = 0;
  always @(posedge ee_cs) begin
    edges = 0;
    trans++;
  end
  always @(posedge ee_sk) begin
    edges++;
    if (edges <= 11) cmd_seen = {cmd_seen[9:0], ee_di};
    else ee_do = memw(int'(cmd_seen[5:0]))[15-(edges-12)];
  end

  logic p_sk = 0, p_cs = 0, p_di = 0;
  int   run = 0, run_min = 0, run_max = 0;
  int   di_bad = 0, cs_bad = 0, sk_bad = 0, done_cnt = 0;
  always @(negedge clk) begin
    if (ee_sk && p_sk && ee_di != p_di) di_bad++;
    if (ee_sk && !ee_cs) sk_bad++;
    if (!ee_cs && p_cs && p_sk) cs_bad++;
    if (!ee_cs && p_cs && ee_di) cs_bad++;
    if (ee_sk != p_sk) begin
      if (run > 0) begin
        if (run_min == 0 || run < run_min) run_min = run;
        if (run > run_max) run_max = run;
      end
      run = 1;
    end else if (ee_cs && (p_sk || ee_sk || edges > 0)) run++;
    if (rd_done) done_cnt++;
    p_sk = ee_sk; p_cs = ee_cs; p_di = ee_di;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic clear_mon();
    run = 0; run_min = 0; run_max = 0;
    di_bad = 0; cs_bad = 0; sk_bad = 0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (rd_done) begin seen = 1; break; end
    end
  endtask

  localparam logic [13:0] VEC [8] = '{
    {6'd0, 8'd1}, {6'd63, 8'd2}, {6'd21, 8'd3}, {6'd42, 8'd1},
    {6'd7, 8'd4}, {6'd1, 8'd0}, {6'd32, 8'd2}, {6'd55, 8'd5}};

  initial begin
    bit          seen;
    int          t0, d0;
    logic [5:0]  a;
    logic [7:0]  dv;
    int          he;

    repeat (3) @(negedge clk);
    chk(ee_cs == 0 && ee_sk == 0 && ee_di == 0, "R10 lines", {ee_cs, ee_sk, ee_di}, 0);
    chk(busy == 0 && rd_done == 0 && boot_done == 0, "R10 flags", {busy, rd_done, boot_done}, 0);
    chk(rd_data == 0 && mac_addr == 0, "R10 data", mac_addr, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    foreach (VEC[k]) begin
      a  = VEC[k][13:8];
      dv = VEC[k][7:0];
      he = (dv == 0) ? 1 : dv;
      clear_mon();
      t0 = trans;
      addr = a; div = dv; start = 1;
      @(negedge clk);
      start = 0;
      wait_done(seen);
      chk(seen, "R8 done seen", seen, 1);
      chk(rd_data == memw(a), "R4 data", rd_data, memw(a));
      chk(cmd_seen == (11'(6 << 6) | 11'(a)), "R1 command", cmd_seen, 11'(6 << 6) | 11'(a));
      chk(edges == 27, "R4 pulse count", edges, 27);
      chk(run_min == he && run_max == he, "R6 half period", run_max, he);
      chk(di_bad == 0, "R2 di steady", di_bad, 0);
      chk(sk_bad == 0, "R3 sk with cs", sk_bad, 0);
      chk(cs_bad == 0, "R5 release order", cs_bad, 0);
      chk(trans == t0 + 1, "R3 single select", trans, t0 + 1);
      @(negedge clk);
      chk(rd_done == 0, "R8 pulse width", rd_done, 0);
    end

    t0 = trans;
    addr = 6'd3; div = 2; start = 1;
    @(negedge clk);
    start = 0;
    repeat (20) @(negedge clk);
    addr = 6'd20; start = 1; boot_start = 1;
    @(negedge clk);
    start = 0; boot_start = 0; addr = 6'd20;
    wait_done(seen);
    chk(rd_data == memw(3), "R7 busy start ignored", rd_data, memw(3));
    repeat (30) @(negedge clk);
    chk(trans == t0 + 1 && busy == 0, "R7 no extra access", trans, t0 + 1);
    chk(mac_addr == 0, "R7 boot ignored", mac_addr, 0);

    d0 = done_cnt;
    t0 = trans;
    div = 1; boot_start = 1;
    @(negedge clk);
    boot_start = 0;
    seen = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (boot_done) begin seen = 1; break; end
    end
    chk(seen, "R9 boot done", seen, 1);
    chk(mac_addr == {memw(7), memw(8), memw(9)}, "R9 station address", mac_addr, {memw(7), memw(8), memw(9)});
    chk(mac_addr[47:40] == memw(7)[15:8], "R9 first byte", mac_addr[47:40], memw(7)[15:8]);
    chk(trans == t0 + 3, "R9 three reads", trans, t0 + 3);
    chk(done_cnt == d0, "R8 no done on boot", done_cnt, d0);
    @(negedge clk);
    chk(boot_done == 0, "R9 pulse width", boot_done, 0);

    clear_mon();
    addr = 6'd9; div = 3; start = 1;
    @(negedge clk);
    start = 0; div = 1;
    wait_done(seen);
    chk(run_min == 3 && run_max == 3, "R6 div captured", run_max, 3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule